// File: doc/BRIEF.md
# Two-Phase Accumulator Sequencer

This block is a very small processor built around one accumulator register. Instructions and data share one word-addressed memory that sits outside the block on a synchronous port. Every instruction is fetched from the word the program counter selects, and then executed. An instruction can copy a memory word into the accumulator, write the accumulator back to memory, or add a memory word into the accumulator. Opcode zero stops the machine. A hold input pauses it at the start of an instruction. The accumulator and program counter are brought out for debug.

An instruction word is 16 bits wide. Bits 15:12 carry the opcode and bits 11:0 carry a word address. The memory returns read data one clock after it captures the address. It writes on the clock edge at which the write enable is high. All memory port outputs of the block are registers.

Top module: `accum_seq`

## Requirements
- R1: While reset is high, and on the first edge after it, the debug program counter and the debug accumulator read 0, the halted flag is low and the write enable is low.
- R2: Each instruction word is read from the address held in the program counter. The opcode is bits 15:12 and the address field is bits 11:0. The program counter grows by one at the decode edge, which is the third clock edge of an instruction.
- R3: Opcode 1 replaces the accumulator with the memory word at the address field.
- R4: Opcode 2 writes the accumulator to the memory word at the address field. The write enable is high for exactly one cycle, and the accumulator does not change.
- R5: Opcode 5 adds the addressed memory word to the accumulator modulo 2^16. No carry is kept.
- R6: Opcode 0 raises the halted flag and leaves the program counter one past the halt word. From then until reset, no memory write occurs and neither the program counter nor the accumulator changes.
- R7: Opcodes 3, 4 and 6 to 15 change neither the accumulator nor memory. Each takes 3 cycles, after which the next word is fetched.
- R8: While the hold input is high at the start of an instruction, no fetch begins, and the program counter and accumulator keep their values.
- R9: Opcodes 1, 2 and 5 take 5 cycles each. The accumulator changes only on the fifth edge of an instruction.
- R10: The program load 940, add 941, store 941, halt leaves the sum of words 940 and 941 in word 941 and in the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold | input | 1 | Pauses the machine before the next fetch |
| mem_addr | output | 12 | Registered memory word address |
| mem_wdata | output | 16 | Registered memory write data |
| mem_we | output | 1 | Registered memory write enable |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| dbg_acc | output | 16 | Accumulator value |
| dbg_pc | output | 12 | Program counter value |
| halted | output | 1 | High once a halt opcode has been decoded |

## Verification
Count the edges from the first edge after reset as 1. Instruction k starts at edge s_k, where s_1 = 1 and each start follows the previous one by 3 cycles for a no-operation and 5 cycles for a memory instruction. The program counter increments at edge s_k+2. A store writes at edge s_k+3. A load or add updates the accumulator at edge s_k+4. The halted flag rises at the decode edge of the halt word. The bench releases reset on a falling edge, waits an exact number of rising edges, and samples 2 ns after the last one. It checks both the edge at which each value changes and the edge just before it, so a result that arrives one cycle early or late is reported.

// File: rtl/accum_pkg.sv
package accum_pkg;
  parameter int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OPC_HALT  = 4'd0;
  localparam logic [OP_W-1:0] OPC_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OPC_STORE = 4'd2;
  localparam logic [OP_W-1:0] OPC_ADD   = 4'd5;

  typedef enum logic [2:0] {
    PH_FETCH, PH_FWAIT, PH_DECODE, PH_EWAIT, PH_EXEC, PH_HALT
  } phase_e;

  typedef enum logic [2:0] {
    K_HALT, K_LOAD, K_STORE, K_ADD, K_NOP
  } kind_e;

  function automatic kind_e classify(input logic [OP_W-1:0] op);
    case (op)
      OPC_HALT:  return K_HALT;
      OPC_LOAD:  return K_LOAD;
      OPC_STORE: return K_STORE;
      OPC_ADD:   return K_ADD;
      default:   return K_NOP;
    endcase
  endfunction
endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [DATA_W-1:0] rdata,
  output phase_e            phase,
  output logic              halted
);
  localparam int unsigned OP_LSB = DATA_W - OP_W;

  phase_e phase_q, phase_d;
  kind_e  kind_now;

  assign kind_now = classify(rdata[DATA_W-1:OP_LSB]);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_FETCH:  phase_d = hold ? PH_FETCH : PH_FWAIT;
      PH_FWAIT:  phase_d = PH_DECODE;
      PH_DECODE: begin
        case (kind_now)
          K_HALT:  phase_d = PH_HALT;
          K_NOP:   phase_d = PH_FETCH;
          default: phase_d = PH_EWAIT;
        endcase
      end
      PH_EWAIT:  phase_d = PH_EXEC;
      PH_EXEC:   phase_d = PH_FETCH;
      default:   phase_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_FETCH;
      halted  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_DECODE && kind_now == K_HALT) halted <= 1'b1;
    end
  end

  assign phase = phase_q;

  // R6: once halted, the phase stays in the halt state
  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && phase_q == PH_HALT));
endmodule

// File: rtl/accum_dp.sv
module accum_dp
  import accum_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_e            phase,
  input  logic              hold,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] acc,
  output logic [ADDR_W-1:0] pc
);
  localparam int unsigned OP_LSB = DATA_W - OP_W;

  kind_e             kind_q;
  kind_e             kind_now;
  logic [ADDR_W-1:0] field;

  assign kind_now = classify(rdata[DATA_W-1:OP_LSB]);
  assign field    = rdata[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      acc       <= '0;
      kind_q    <= K_NOP;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
    end else begin
      case (phase)
        PH_FETCH: begin
          mem_we <= 1'b0;
          if (!hold) mem_addr <= pc;
        end
        PH_DECODE: begin
          kind_q <= kind_now;
          pc     <= pc + 1'b1;
          if (kind_now == K_LOAD || kind_now == K_ADD || kind_now == K_STORE)
            mem_addr <= field;
          if (kind_now == K_STORE) begin
            mem_we    <= 1'b1;
            mem_wdata <= acc;
          end
        end
        PH_EWAIT: mem_we <= 1'b0;
        PH_EXEC: begin
          if (kind_q == K_LOAD) acc <= rdata;
          else if (kind_q == K_ADD) acc <= acc + rdata;
        end
        default: mem_we <= 1'b0;
      endcase
    end
  end

  // R2: program counter advances by one after a decode
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECODE) |=> (pc == $past(pc) + 1'b1));

  // R4: stored data equals the accumulator, write is a single pulse
  assert_store_data_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == acc));
  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R9: accumulator only changes out of the execute phase
  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_EXEC) |=> $stable(acc));
endmodule

// File: rtl/accum_seq.sv
module accum_seq
  import accum_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] dbg_acc,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic              halted
);
  phase_e phase;

  accum_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .hold   (hold),
    .rdata  (mem_rdata),
    .phase  (phase),
    .halted (halted)
  );

  accum_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .hold      (hold),
    .rdata     (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .acc       (dbg_acc),
    .pc        (dbg_pc)
  );

  // R6: nothing moves once halted
  assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    halted |=> ($stable(dbg_pc) && $stable(dbg_acc) && !mem_we));

  // R8: a held fetch leaves state untouched
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH && hold) |=> ($stable(dbg_pc) && $stable(dbg_acc) && !mem_we));
endmodule

// File: tb/accum_seq_bench.sv
module accum_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hold = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic [15:0] dbg_acc;
  logic [11:0] dbg_pc;
  logic        halted;

  logic [15:0] mem [0:4095];
  logic        tb_we = 1'b0;
  logic [11:0] tb_addr = '0;
  logic [15:0] tb_data = '0;
  int          wr_count = 0;
  int          checks = 0;
  int          fails = 0;

  always #10 clk = ~clk;

  accum_seq u_accum_seq (
    .clk(clk), .rst(rst), .hold(hold),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .dbg_acc(dbg_acc), .dbg_pc(dbg_pc), .halted(halted)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
    if (!rst && mem_we) wr_count <= wr_count + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_addr = a; tb_data = d;
    @(posedge clk);
    #1 tb_we = 1'b0;
  endtask

  task automatic start_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic release_reset();
    @(negedge clk);
    wr_count = 0;
    rst = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_halt(input int limit, input string tag);
    int n = 0;
    while (!halted && n < limit) begin
      @(posedge clk); #2; n++;
    end
    check(halted, tag, halted, 1);
  endtask

  task automatic t_example();
    start_reset();
    poke(12'd0, 16'h13AC); poke(12'd1, 16'h53AD);
    poke(12'd2, 16'h23AD); poke(12'd3, 16'h0000);
    poke(12'd940, 16'd1234); poke(12'd941, 16'd4321);
    release_reset();
    step(2);  check(dbg_pc == 12'd0, "R2 pc before decode", dbg_pc, 0);
    step(1);  check(dbg_pc == 12'd1, "R2 pc after decode", dbg_pc, 1);
    step(1);  check(dbg_acc == 16'd0, "R9 acc before fifth edge", dbg_acc, 0);
    step(1);  check(dbg_acc == 16'd1234, "R3 load result", dbg_acc, 1234);
    step(4);  check(dbg_acc == 16'd1234, "R9 add not yet", dbg_acc, 1234);
    step(1);  check(dbg_acc == 16'd5555, "R5 add result", dbg_acc, 5555);
    step(3);  check(wr_count == 0, "R4 no write before fourth edge", wr_count, 0);
    step(1);  check(wr_count == 1, "R4 write at fourth edge", wr_count, 1);
    step(3);  check(!halted, "R6 halted early", halted, 0);
    step(1);  check(halted, "R6 halted at decode", halted, 1);
    check(dbg_pc == 12'd4, "R6 pc past halt", dbg_pc, 4);
    check(mem[941] == 16'd5555, "R10 sum in word 941", mem[941], 5555);
    check(dbg_acc == 16'd5555, "R10 sum in acc", dbg_acc, 5555);
    check(dbg_acc == 16'd5555, "R4 acc unchanged by store", dbg_acc, 5555);
  endtask

  task automatic t_reset();
    start_reset();
    step(1);
    check(dbg_pc == 12'd0, "R1 pc", dbg_pc, 0);
    check(dbg_acc == 16'd0, "R1 acc", dbg_acc, 0);
    check(!halted, "R1 halted", halted, 0);
    check(!mem_we, "R1 we", mem_we, 0);
  endtask

  task automatic t_wrap_halt();
    start_reset();
    poke(12'd0, 16'h1200); poke(12'd1, 16'h5201);
    poke(12'd2, 16'h0000); poke(12'd3, 16'h2202);
    poke(12'h200, 16'hFFF0); poke(12'h201, 16'h0020); poke(12'h202, 16'h7777);
    release_reset();
    wait_halt(100, "R6 halt reached");
    check(dbg_acc == 16'h0010, "R5 wrap", dbg_acc, 16'h0010);
    check(dbg_pc == 12'd3, "R6 pc at halt", dbg_pc, 3);
    step(30);
    check(dbg_pc == 12'd3, "R6 pc frozen", dbg_pc, 3);
    check(wr_count == 0, "R6 no writes", wr_count, 0);
    check(mem[12'h202] == 16'h7777, "R6 word after halt untouched", mem[12'h202], 16'h7777);
  endtask

  task automatic t_nop();
    start_reset();
    poke(12'd0, 16'h1100); poke(12'd1, 16'h3101); poke(12'd2, 16'hF102);
    poke(12'd3, 16'h2103); poke(12'd4, 16'h0000);
    poke(12'h100, 16'hBEEF); poke(12'h101, 16'h1111);
    poke(12'h102, 16'h2222); poke(12'h103, 16'h0000);
    release_reset();
    step(8);  check(dbg_pc == 12'd2, "R7 first nop takes 3 cycles", dbg_pc, 2);
    step(3);  check(dbg_pc == 12'd3, "R7 second nop takes 3 cycles", dbg_pc, 3);
    check(dbg_acc == 16'hBEEF, "R7 acc kept over nops", dbg_acc, 16'hBEEF);
    wait_halt(100, "R7 halt reached");
    check(mem[12'h101] == 16'h1111, "R7 op3 no write", mem[12'h101], 16'h1111);
    check(mem[12'h102] == 16'h2222, "R7 op15 no write", mem[12'h102], 16'h2222);
    check(mem[12'h103] == 16'hBEEF, "R4 stored value", mem[12'h103], 16'hBEEF);
    check(wr_count == 1, "R7 only the store writes", wr_count, 1);
    check(dbg_pc == 12'd5, "R2 pc count", dbg_pc, 5);
  endtask

  task automatic t_hold();
    start_reset();
    poke(12'd0, 16'h3000); poke(12'd1, 16'h3000);
    poke(12'd2, 16'h0000);
    @(negedge clk); hold = 1'b1;
    release_reset();
    step(12);
    check(dbg_pc == 12'd0, "R8 pc held", dbg_pc, 0);
    check(!halted, "R8 not running", halted, 0);
    @(negedge clk); hold = 1'b0;
    step(2);  check(dbg_pc == 12'd0, "R8 pc before decode", dbg_pc, 0);
    step(1);  check(dbg_pc == 12'd1, "R8 pc after release", dbg_pc, 1);
    wait_halt(100, "R8 halt reached");
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected halt");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_example();
    t_reset();
    t_wrap_halt();
    t_nop();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule